// File: doc/BRIEF.md
# Write-Allocate Store Merge Buffer

This block sits between a core's store path and the external memory port of a write-allocate data cache. Every store presented to it has already missed in the cache. The first store to a line claims a free line-sized entry, which records the line address, a byte-valid mask and the bytes written so far. The entry then waits for the block to request that line from memory. Later stores to the same line go into the same entry and start no further request. The line is 32 bytes, made of eight 32-bit words.

A line can be written into the cache as a dirty line in two ways:
- Stores cover all 32 bytes of the line. The line is then installed at once. If no request was sent yet, none is ever sent. If a request is already out, the data it brings back is thrown away.
- The fill returns for a partly written line. The block combines it byte by byte with the stored bytes, and the stored bytes win.

The number of fills in flight is capped by a parameter. While the cap holds requests back, stores keep going into their entries. A line completed in that time never costs a memory read. Each request carries the entry number as its transaction ID, so responses may return in any order. Three event pulses feed a performance counter:
- one for each accepted store,
- one for each fill request actually handed to memory,
- one for each line install, since every install displaces a victim line in the cache.

Top module: `wa_merge_buf`

## Requirements
- R1: After reset, `st_ready` is 1 and `mrq_valid`, `inst_valid` and all three event outputs are 0.
- R2: A store to a line with no live entry takes a free entry. One cycle after it is accepted, a fill request is raised with `mrq_addr` = `st_addr[31:5]` and an ID that names the entry. This happens only if the fill cap allows it.
- R3: A store to a line whose entry is live joins that entry and raises no further fill request. Store byte k (bits 8k+7:8k of `st_data`, enabled by `st_strb[k]`) lands in line byte 4*`st_addr[4:2]`+k.
- R4: When stores have covered all 32 bytes of a line and no request has gone out for it, the line is installed with the stored bytes and no fill request is ever issued for it. Line byte i is carried on `inst_line[8i+7:8i]`.
- R5: When stores cover a line whose fill is already in flight, the line is installed from the stored bytes. The response that later arrives for its ID produces no install.
- R6: At most MAX_FILL fills (default 2) are outstanding. While that many are out, `mrq_valid` stays low. When a response arrives, the oldest waiting entry, by lowest entry number, is issued next.
- R7: A response to a partly written line installs that line one cycle later. Each byte comes from the stored data where its valid bit is set, and from the response elsewhere.
- R8: Responses are matched by `mrs_id`, in whatever order they arrive.
- R9: `st_ready` is 0 only when the presented line has no live entry and every entry is in use. A store to a line that already has a live entry is always accepted.
- R10: `evt_store` pulses for each accepted store, `evt_fill` pulses for each request handshake, and `evt_evict` pulses with each install. A line completed by stores adds nothing to `evt_fill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store present |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | ADDR_W | Store byte address (word aligned) |
| st_data | input | 32 | Store word |
| st_strb | input | 4 | Byte enables of the store word |
| mrq_valid | output | 1 | Fill request valid |
| mrq_ready | input | 1 | Memory accepts the request |
| mrq_addr | output | ADDR_W-5 | Line address of the request |
| mrq_id | output | clog2(NUM_ENT) | Transaction ID (entry number) |
| mrs_valid | input | 1 | Fill response valid |
| mrs_id | input | clog2(NUM_ENT) | Transaction ID of the response |
| mrs_line | input | 256 | Returned line data |
| inst_valid | output | 1 | Dirty line install into the cache |
| inst_addr | output | ADDR_W-5 | Line address of the install |
| inst_line | output | 256 | Line data to install |
| evt_store | output | 1 | Store event pulse |
| evt_evict | output | 1 | Eviction event pulse |
| evt_fill | output | 1 | Linefill issued event pulse |

## Verification
Each result arrives at a fixed number of clock edges after its stimulus:
- `evt_store` and `st_ready` are combinational and are valid in the same cycle as the store.
- A fill request appears one edge after the store that allocated the entry.
- A line completed by stores is installed two edges after the last store is accepted: one edge updates the mask, the next registers the install.
- A line completed by a response is installed one edge after that response.

The bench changes inputs just after a rising edge and samples only on falling edges. After each store or response it waits four cycles before checking its event counters and the last captured install. This margin covers every one of these latencies without depending on exact edge alignment.

// File: rtl/wamb_pkg.sv
package wamb_pkg;

  localparam int LINE_BYTES = 32;
  localparam int WORD_BYTES = 4;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFS_W      = $clog2(LINE_BYTES);
  localparam int WIDX_W     = $clog2(LINE_BYTES / WORD_BYTES);

  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_MERGE = 2'd1,
    ENT_WAIT  = 2'd2,
    ENT_DRAIN = 2'd3
  } ent_state_e;

  // byte-valid bits a store word sets inside the line
  function automatic logic [LINE_BYTES-1:0] lane_mask(input logic [WIDX_W-1:0] widx,
                                                      input logic [WORD_BYTES-1:0] strb);
    lane_mask = LINE_BYTES'(strb) << (WORD_BYTES * widx);
  endfunction

  // store word shifted to its place in the line
  function automatic logic [LINE_W-1:0] lane_data(input logic [WIDX_W-1:0] widx,
                                                  input logic [31:0] data);
    lane_data = LINE_W'(data) << (32 * widx);
  endfunction

  // take bytes of 'over' where mask is set, 'base' elsewhere
  function automatic logic [LINE_W-1:0] byte_merge(input logic [LINE_W-1:0] base,
                                                   input logic [LINE_W-1:0] over,
                                                   input logic [LINE_BYTES-1:0] mask);
    for (int i = 0; i < LINE_BYTES; i++)
      byte_merge[8*i +: 8] = mask[i] ? over[8*i +: 8] : base[8*i +: 8];
  endfunction

endpackage

// File: rtl/wamb_entry.sv
module wamb_entry
  import wamb_pkg::*;
#(
  parameter int LA_W = 27
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc,
  input  logic                  st_we,
  input  logic [LA_W-1:0]       st_tag,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic [LINE_W-1:0]     st_line,
  input  logic                  rsp_we,
  input  logic [LINE_W-1:0]     rsp_line,
  input  logic                  issue,
  input  logic                  retire,
  output ent_state_e            state,
  output logic [LA_W-1:0]       tag,
  output logic                  full_now,
  output logic                  full_upd,
  output logic [LINE_W-1:0]     line_upd
);

  ent_state_e            state_q, state_d;
  logic [LA_W-1:0]       tag_q;
  logic [LINE_BYTES-1:0] mask_q, mask_b, mask_s;
  logic [LINE_W-1:0]     data_q, data_b, data_s;

  always_comb begin
    mask_b   = alloc ? '0 : mask_q;
    data_b   = alloc ? '0 : data_q;
    mask_s   = st_we ? (mask_b | st_mask) : mask_b;
    data_s   = st_we ? byte_merge(data_b, st_line, st_mask) : data_b;
    // stored bytes win over returned fill bytes
    line_upd = rsp_we ? byte_merge(rsp_line, data_s, mask_s) : data_s;
    full_upd = &mask_s;
    full_now = &mask_q;
  end

  always_comb begin
    state_d = state_q;
    if (alloc) begin
      state_d = ENT_MERGE;
    end else if (rsp_we) begin
      if (state_q == ENT_DRAIN)
        state_d = ENT_FREE;
      else if (state_q == ENT_WAIT)
        state_d = full_upd ? ENT_MERGE : ENT_FREE;
    end else if (retire) begin
      state_d = (state_q == ENT_WAIT) ? ENT_DRAIN : ENT_FREE;
    end else if (issue) begin
      state_d = ENT_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENT_FREE;
      tag_q   <= '0;
      mask_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (alloc) tag_q <= st_tag;
      mask_q  <= mask_s;
      data_q  <= data_s;
    end
  end

  assign state = state_q;
  assign tag   = tag_q;

endmodule

// File: rtl/wamb_fill_ctl.sv
module wamb_fill_ctl #(
  parameter int NUM_ENT  = 4,
  parameter int MAX_FILL = 2,
  parameter int LA_W     = 27,
  parameter int ID_W     = 2,
  parameter int CNT_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_ENT-1:0]            cand,
  input  logic [NUM_ENT-1:0][LA_W-1:0]  tags,
  input  logic                          mrq_ready,
  input  logic                          rsp_done,
  output logic [NUM_ENT-1:0]            issue,
  output logic                          mrq_valid,
  output logic [ID_W-1:0]               mrq_id,
  output logic [LA_W-1:0]               mrq_addr,
  output logic                          evt_fill,
  output logic [CNT_W-1:0]              fill_cnt
);

  logic             req_q;
  logic [ID_W-1:0]  id_q, pick;
  logic [LA_W-1:0]  addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             found, room;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick  = ID_W'(i);
        found = 1'b1;
      end
    end
    room  = !req_q && (cnt_q < CNT_W'(MAX_FILL));
    issue = '0;
    if (room && found) issue[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      id_q   <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (req_q && mrq_ready) req_q <= 1'b0;
      if (|issue) begin
        req_q  <= 1'b1;
        id_q   <= pick;
        addr_q <= tags[pick];
      end
      cnt_q <= cnt_q + CNT_W'(|issue) - CNT_W'(rsp_done);
    end
  end

  assign mrq_valid = req_q;
  assign mrq_id    = id_q;
  assign mrq_addr  = addr_q;
  assign evt_fill  = req_q && mrq_ready;
  assign fill_cnt  = cnt_q;

endmodule

// File: rtl/wa_merge_buf.sv
module wa_merge_buf
  import wamb_pkg::*;
#(
  parameter  int ADDR_W   = 32,
  parameter  int NUM_ENT  = 4,
  parameter  int MAX_FILL = 2,
  localparam int LA_W     = ADDR_W - OFS_W,
  localparam int ID_W     = $clog2(NUM_ENT),
  localparam int CNT_W    = $clog2(MAX_FILL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [31:0]       st_data,
  input  logic [3:0]        st_strb,
  output logic              mrq_valid,
  input  logic              mrq_ready,
  output logic [LA_W-1:0]   mrq_addr,
  output logic [ID_W-1:0]   mrq_id,
  input  logic              mrs_valid,
  input  logic [ID_W-1:0]   mrs_id,
  input  logic [LINE_W-1:0] mrs_line,
  output logic              inst_valid,
  output logic [LA_W-1:0]   inst_addr,
  output logic [LINE_W-1:0] inst_line,
  output logic              evt_store,
  output logic              evt_evict,
  output logic              evt_fill
);

  ent_state_e                  ent_st [NUM_ENT];
  logic [NUM_ENT-1:0][LA_W-1:0] tag_pk;
  logic [LINE_W-1:0]           line_upd [NUM_ENT];
  logic [NUM_ENT-1:0]          full_now, full_upd;
  logic [NUM_ENT-1:0]          hit_vec, free_vec, fly_vec, alloc_vec, we_vec;
  logic [NUM_ENT-1:0]          rsp_vec, retire_vec, issue_vec, cand_vec;
  logic [LA_W-1:0]             st_tag;
  logic [LINE_BYTES-1:0]       st_mask;
  logic [LINE_W-1:0]           st_line;
  logic                        hit, rsp_inst, ret_found, take;
  logic [ID_W-1:0]             alloc_pick, ret_pick, inst_sel;
  logic [CNT_W-1:0]            fill_cnt;

  logic                        inst_valid_q;
  logic [LA_W-1:0]             inst_addr_q;
  logic [LINE_W-1:0]           inst_line_q;

  assign st_tag  = st_addr[ADDR_W-1:OFS_W];
  assign st_mask = lane_mask(st_addr[OFS_W-1:2], st_strb);
  assign st_line = lane_data(st_addr[OFS_W-1:2], st_data);

  // store side: hit lookup, allocation
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      hit_vec[i]  = (ent_st[i] == ENT_MERGE || ent_st[i] == ENT_WAIT) && (tag_pk[i] == st_tag);
      free_vec[i] = (ent_st[i] == ENT_FREE);
      fly_vec[i]  = (ent_st[i] == ENT_WAIT || ent_st[i] == ENT_DRAIN);
      rsp_vec[i]  = mrs_valid && (mrs_id == ID_W'(i));
    end
    hit        = |hit_vec;
    alloc_pick = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (free_vec[i]) alloc_pick = ID_W'(i);
    st_ready  = hit || (|free_vec);
    take      = st_valid && st_ready;
    alloc_vec = '0;
    if (take && !hit) alloc_vec[alloc_pick] = 1'b1;
    we_vec    = take ? (hit ? hit_vec : alloc_vec) : '0;
  end

  // install side: response merge has priority over a fully written line
  always_comb begin
    rsp_inst  = mrs_valid && (ent_st[mrs_id] == ENT_WAIT) && !full_upd[mrs_id];
    ret_pick  = '0;
    ret_found = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if ((ent_st[i] == ENT_MERGE || ent_st[i] == ENT_WAIT) && full_now[i] && !rsp_vec[i]) begin
        ret_pick  = ID_W'(i);
        ret_found = !rsp_inst;
      end
    end
    retire_vec = '0;
    if (ret_found) retire_vec[ret_pick] = 1'b1;
    inst_sel = rsp_inst ? mrs_id : ret_pick;
    for (int i = 0; i < NUM_ENT; i++)
      cand_vec[i] = (ent_st[i] == ENT_MERGE) && !full_upd[i];
  end

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      wamb_entry #(.LA_W(LA_W)) u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (alloc_vec[g]),
        .st_we    (we_vec[g]),
        .st_tag   (st_tag),
        .st_mask  (st_mask),
        .st_line  (st_line),
        .rsp_we   (rsp_vec[g]),
        .rsp_line (mrs_line),
        .issue    (issue_vec[g]),
        .retire   (retire_vec[g]),
        .state    (ent_st[g]),
        .tag      (tag_pk[g]),
        .full_now (full_now[g]),
        .full_upd (full_upd[g]),
        .line_upd (line_upd[g])
      );
    end
  endgenerate

  wamb_fill_ctl #(
    .NUM_ENT (NUM_ENT),
    .MAX_FILL(MAX_FILL),
    .LA_W    (LA_W),
    .ID_W    (ID_W),
    .CNT_W   (CNT_W)
  ) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (cand_vec),
    .tags     (tag_pk),
    .mrq_ready(mrq_ready),
    .rsp_done (mrs_valid),
    .issue    (issue_vec),
    .mrq_valid(mrq_valid),
    .mrq_id   (mrq_id),
    .mrq_addr (mrq_addr),
    .evt_fill (evt_fill),
    .fill_cnt (fill_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inst_valid_q <= 1'b0;
      inst_addr_q  <= '0;
      inst_line_q  <= '0;
    end else begin
      inst_valid_q <= rsp_inst || ret_found;
      inst_addr_q  <= tag_pk[inst_sel];
      inst_line_q  <= line_upd[inst_sel];
    end
  end

  assign inst_valid = inst_valid_q;
  assign inst_addr  = inst_addr_q;
  assign inst_line  = inst_line_q;
  assign evt_store  = take;
  assign evt_evict  = inst_valid_q;

endmodule

// File: rtl/wamb_chk.sv
module wamb_chk #(
  parameter int NUM_ENT  = 4,
  parameter int MAX_FILL = 2,
  parameter int LA_W     = 27,
  parameter int ID_W     = 2,
  parameter int CNT_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_ready,
  input logic               mrq_valid,
  input logic               mrq_ready,
  input logic [ID_W-1:0]    mrq_id,
  input logic [LA_W-1:0]    mrq_addr,
  input logic [CNT_W-1:0]   fill_cnt,
  input logic [NUM_ENT-1:0] free_vec,
  input logic [NUM_ENT-1:0] fly_vec,
  input logic [NUM_ENT-1:0] issue_vec
);

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(MAX_FILL)); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mrq_valid && !mrq_ready |=> mrq_valid && $stable(mrq_addr) && $stable(mrq_id)); // R2

  AST_REQ_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    mrq_valid |-> fly_vec[mrq_id]); // R8

  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> (free_vec == '0)); // R9

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_vec)); // R3

endmodule

bind wa_merge_buf wamb_chk #(
  .NUM_ENT (NUM_ENT),
  .MAX_FILL(MAX_FILL),
  .LA_W    (LA_W),
  .ID_W    (ID_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .st_ready (st_ready),
  .mrq_valid(mrq_valid),
  .mrq_ready(mrq_ready),
  .mrq_id   (mrq_id),
  .mrq_addr (mrq_addr),
  .fill_cnt (fill_cnt),
  .free_vec (free_vec),
  .fly_vec  (fly_vec),
  .issue_vec(issue_vec)
);

// File: tb/test_wa_merge_buf.sv
module test_wa_merge_buf;

  localparam int ADDR_W = 32;
  localparam int LA_W   = 27;
  localparam int ID_W   = 2;

  typedef struct packed {
    logic [2:0]  widx;
    logic [3:0]  strb;
    logic [31:0] data;
  } vec_t;

  // stores that together cover one whole line, out of order, word 0 in two halves
  localparam vec_t TV [9] = '{
    '{3'd3, 4'b1111, 32'h3A3B3C3D},
    '{3'd0, 4'b0011, 32'hFFFF0A0B},
    '{3'd7, 4'b1111, 32'h7A7B7C7D},
    '{3'd1, 4'b1111, 32'h1A1B1C1D},
    '{3'd6, 4'b1111, 32'h6A6B6C6D},
    '{3'd0, 4'b1100, 32'h0C0D5555},
    '{3'd2, 4'b1111, 32'h2A2B2C2D},
    '{3'd5, 4'b1111, 32'h5A5B5C5D},
    '{3'd4, 4'b1111, 32'h4A4B4C4D}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              st_valid = 1'b0;
  logic              st_ready;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [31:0]       st_data = '0;
  logic [3:0]        st_strb = '0;
  logic              mrq_valid;
  logic              mrq_ready = 1'b1;
  logic [LA_W-1:0]   mrq_addr;
  logic [ID_W-1:0]   mrq_id;
  logic              mrs_valid = 1'b0;
  logic [ID_W-1:0]   mrs_id = '0;
  logic [255:0]      mrs_line = '0;
  logic              inst_valid;
  logic [LA_W-1:0]   inst_addr;
  logic [255:0]      inst_line;
  logic              evt_store, evt_evict, evt_fill;

  int n_chk = 0, n_err = 0;
  int n_store = 0, n_fill = 0, n_inst = 0, n_evict = 0;
  logic [LA_W-1:0] log_addr [16];
  logic [ID_W-1:0] log_id   [16];
  logic [LA_W-1:0] last_addr;
  logic [255:0]    last_line;

  always #2 clk = ~clk;

  wa_merge_buf i_wa_merge_buf (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_strb(st_strb),
    .mrq_valid(mrq_valid), .mrq_ready(mrq_ready), .mrq_addr(mrq_addr), .mrq_id(mrq_id),
    .mrs_valid(mrs_valid), .mrs_id(mrs_id), .mrs_line(mrs_line),
    .inst_valid(inst_valid), .inst_addr(inst_addr), .inst_line(inst_line),
    .evt_store(evt_store), .evt_evict(evt_evict), .evt_fill(evt_fill)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_store) n_store++;
      if (evt_evict) n_evict++;
      if (evt_fill) begin
        log_addr[n_fill[3:0]] = mrq_addr;
        log_id[n_fill[3:0]]   = mrq_id;
        n_fill++;
      end
      if (inst_valid) begin
        n_inst++;
        last_addr = inst_addr;
        last_line = inst_line;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = a; st_data = d; st_strb = s;
    do @(negedge clk); while (!st_ready);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_rsp(input logic [ID_W-1:0] id, input logic [255:0] line);
    @(posedge clk); #1;
    mrs_valid = 1'b1; mrs_id = id; mrs_line = line;
    @(posedge clk); #1;
    mrs_valid = 1'b0;
  endtask

  task automatic write_line(input logic [31:0] base, input logic [31:0] salt);
    for (int v = 0; v < 9; v++)
      do_store(base + {27'd0, TV[v].widx, 2'b00}, TV[v].data ^ salt, TV[v].strb);
  endtask

  function automatic logic [255:0] table_line(input logic [31:0] salt);
    logic [255:0] e = '0;
    for (int v = 0; v < 9; v++)
      for (int k = 0; k < 4; k++)
        if (TV[v].strb[k]) e[(int'(TV[v].widx) * 4 + k) * 8 +: 8] = TV[v].data[8*k +: 8] ^ salt[8*k +: 8];
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] e;
    int f0, i0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(st_ready && !mrq_valid && !inst_valid && !evt_store && !evt_fill && !evt_evict,
        "R1 reset", {st_ready, mrq_valid, inst_valid, evt_store, evt_fill, evt_evict}, 256'h20);

    // R2 first miss on line A issues one fill
    do_store(32'h0000_2000, 32'h0000_00AA, 4'b0001);
    wait_cyc(4);
    chk(n_fill == 1 && log_addr[0] == 27'h100, "R2 fill addr", {log_addr[0], 32'(n_fill)}, {27'h100, 32'd1});
    // R3 merge into A, no extra fill
    do_store(32'h0000_2004, 32'h5566_7788, 4'b1111);
    wait_cyc(4);
    chk(n_fill == 1, "R3 no extra fill", n_fill, 1);
    chk(n_store == 2, "R10 store events", n_store, 2);

    // line B partial -> second fill, cap reached
    do_store(32'h0000_203C, 32'hBB00_0000, 4'b1000);
    wait_cyc(4);
    chk(n_fill == 2 && log_addr[1] == 27'h101, "R2 second fill", n_fill, 2);

    // R4/R6 line C fully written while cap holds
    write_line(32'h0000_2040, 32'h0);
    wait_cyc(4);
    chk(n_fill == 2 && !mrq_valid, "R6 cap holds, R4 no fill for full line", n_fill, 2);
    chk(n_inst == 1 && last_addr == 27'h102, "R4 install addr", last_addr, 27'h102);
    chk(last_line == table_line(32'h0), "R4 install data", last_line, table_line(32'h0));
    chk(n_evict == 1, "R10 evict event", n_evict, 1);

    // R8 respond B first (out of order), R7 byte priority
    do_rsp(log_id[1], {32{8'h22}});
    wait_cyc(4);
    e = {32{8'h22}}; e[255:248] = 8'hBB;
    chk(n_inst == 2 && last_addr == 27'h101, "R8 match by id", last_addr, 27'h101);
    chk(last_line == e, "R7 merge B", last_line, e);
    do_rsp(log_id[0], {32{8'h11}});
    wait_cyc(4);
    e = {32{8'h11}}; e[7:0] = 8'hAA; e[63:32] = 32'h5566_7788;
    chk(n_inst == 3 && last_addr == 27'h100, "R8 match A", last_addr, 27'h100);
    chk(last_line == e, "R7 merge A", last_line, e);

    // R5 line D filled while its fill is in flight
    write_line(32'h0000_2080, 32'hFFFF_FFFF);
    wait_cyc(4);
    chk(n_fill == 3 && log_addr[2] == 27'h104, "R5 fill issued for D", n_fill, 3);
    chk(n_inst == 4 && last_line == table_line(32'hFFFF_FFFF), "R5 install D", last_line, table_line(32'hFFFF_FFFF));
    i0 = n_inst;
    do_rsp(log_id[2], {32{8'h99}});
    wait_cyc(4);
    chk(n_inst == i0, "R5 late fill dropped", n_inst, i0);

    // R9 all entries busy
    f0 = n_fill;
    do_store(32'h0000_3000, 32'h1, 4'b0001);
    do_store(32'h0000_3020, 32'h2, 4'b0001);
    do_store(32'h0000_3040, 32'h3, 4'b0001);
    do_store(32'h0000_3060, 32'h4, 4'b0001);
    wait_cyc(4);
    chk(n_fill == f0 + 2 && !mrq_valid, "R6 only two fills out", n_fill, f0 + 2);
    @(posedge clk); #1 st_addr = 32'h0000_3080;
    @(negedge clk);
    chk(!st_ready, "R9 ready low when full", st_ready, 0);
    @(posedge clk); #1 st_addr = 32'h0000_3004;
    @(negedge clk);
    chk(st_ready, "R9 hit still accepted", st_ready, 1);
    do_rsp(log_id[f0[3:0]], {32{8'h00}});
    wait_cyc(4);
    chk(n_fill == f0 + 3 && log_addr[(f0 + 2) % 16] == 27'h182, "R6 next fill after completion",
        log_addr[(f0 + 2) % 16], 27'h182);
    @(posedge clk); #1 st_addr = 32'h0000_3080;
    @(negedge clk);
    chk(st_ready, "R9 ready after free", st_ready, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule